// File: doc/BRIEF.md
# Load/Store Address and Data Unit

This unit sits between the register read stage and the data memory port of a 32-bit load/store pipeline. From a base register value and an offset, it forms the effective memory address. It also produces the value to write back into the base register and the byte-lane enables for the access. When read data returns from memory, the unit picks out the addressed byte, halfword or word and extends it to a full register value.

Three indexing modes are supported:
- **Offset mode** leaves the base register untouched.
- **Pre-indexed mode** uses the adjusted address for the access and also writes it back.
- **Post-indexed mode** accesses at the original base and writes the adjusted value back.

The offset can be one of three sources: a zero-extended immediate, an index register, or an index register shifted left.

Byte-lane ordering is little-endian by default. A configuration input selects big-endian ordering instead. That input is captured only while reset is held.

All address, writeback and load-result outputs are combinational functions of the current inputs. The only storage in the unit is the captured endianness bit.

Top module: `lsu_addr_unit`

## Requirements
- R1: With `mode_i` = 0 (offset) or 3 (treated as offset), `addr_o` equals base plus or minus the offset and `wb_en_o` is 0.
- R2: With `mode_i` = 1 (pre-indexed), `addr_o` equals base plus or minus the offset, `wb_en_o` is 1 and `wb_data_o` equals `addr_o`.
- R3: With `mode_i` = 2 (post-indexed), `addr_o` equals `base_i`, `wb_en_o` is 1 and `wb_data_o` equals base plus or minus the offset.
- R4: The offset source is selected by `off_sel_i`:
  - 0: `imm_i` zero-extended.
  - 1: `index_i`.
  - 2: `index_i << shamt_i`.
  - 3: behaves as 0.
  
  `sub_i` = 1 subtracts the offset from the base; `sub_i` = 0 adds it.
- R5: An unsigned byte load (`size_i` = 0, `signed_i` = 0) returns the selected byte in bits 7:0 with bits 31:8 cleared.
- R6: A signed byte load (`size_i` = 0, `signed_i` = 1) returns the selected byte in bits 7:0 with bits 31:8 equal to its bit 7.
- R7: A halfword load (`size_i` = 1) returns the selected 16 bits in bits 15:0. Bits 31:16 are zero when unsigned, or copies of bit 15 when signed. Address bit 0 is ignored for halfwords.
- R8: Lane mapping depends on the captured endianness:
  - Little-endian: the byte at address offset a (`addr_o[1:0]`) is lane a, meaning `rdata_i[8a+7:8a]`. The halfword at `addr_o[1]`=h is `rdata_i[16h+15:16h]`.
  - Big-endian: the byte is lane 3-a, and the halfword is `rdata_i[16(1-h)+15:16(1-h)]`.
  - A word (`size_i` = 2 or 3) returns `rdata_i` unchanged in either order.
- R9: `byte_en_o` has bit k set for each lane k touched by the access, following the same lane map as R8:
  - byte: one lane;
  - halfword: two lanes;
  - word: 4'b1111.
  
  When `access_i` = 0, both `byte_en_o` and `wb_en_o` are 0.
- R10: `cfg_big_endian_i` (1 = big-endian) is sampled on each clock edge while `rst_n` is low. Changes to it after reset is released have no effect.
- R11: `addr_o`, `byte_en_o`, `wb_en_o`, `wb_data_o` and `load_data_o` reflect the inputs and `rdata_i` in the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the endianness capture |
| rst_n | input | 1 | Active-low reset; endianness sampled while low |
| cfg_big_endian_i | input | 1 | 1 selects big-endian lane order |
| access_i | input | 1 | An access is being presented this cycle |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset |
| index_i | input | 32 | Index register value |
| shamt_i | input | 5 | Left shift applied to the index register |
| off_sel_i | input | 2 | Offset source select |
| sub_i | input | 1 | 1 subtracts the offset |
| mode_i | input | 2 | Indexing mode |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| signed_i | input | 1 | Sign-extend sub-word loads |
| rdata_i | input | 32 | Read data from memory |
| addr_o | output | 32 | Effective address |
| byte_en_o | output | 4 | Byte-lane enables |
| wb_en_o | output | 1 | Base register writeback enable |
| wb_data_o | output | 32 | Base register writeback value |
| load_data_o | output | 32 | Extended load result |

## Verification
Every data output is due zero cycles after its stimulus. The address, enables and writeback value follow the operand inputs, and the load result follows `rdata_i` within the same cycle. The bench therefore drives each vector just after a falling edge and samples one nanosecond later, before any rising edge can intervene.

The endianness choice is the one result that depends on clock edges. It only takes effect once reset has been held low across at least one rising edge. The bench holds reset for three edges before it checks the lane order, then changes the configuration input with reset high and verifies that the lane order does not change.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        IDX_OFFSET = 2'd0,
        IDX_PRE    = 2'd1,
        IDX_POST   = 2'd2,
        IDX_RSVD   = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        OFS_IMM     = 2'd0,
        OFS_REG     = 2'd1,
        OFS_REG_SHL = 2'd2,
        OFS_RSVD    = 2'd3
    } ofs_src_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic big_endian;
    } cfg_state_t;

endpackage

// File: rtl/lsu_offset_gen.sv
module lsu_offset_gen
    import lsu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [1:0]         src_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [DATA_W-1:0]  index_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [DATA_W-1:0]  offset_o
);

    typedef struct packed {
        logic [DATA_W-1:0] offset;
    } ofs_calc_t;

    ofs_calc_t calc_d;
    ofs_src_e  src;

    assign src = ofs_src_e'(src_i);

    always_comb begin
        calc_d.offset = {{(DATA_W-IMM_W){1'b0}}, imm_i};
        case (src)
            OFS_REG:     calc_d.offset = index_i;
            OFS_REG_SHL: calc_d.offset = index_i << shamt_i;
            default:     calc_d.offset = {{(DATA_W-IMM_W){1'b0}}, imm_i};
        endcase
    end

    assign offset_o = calc_d.offset;

endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              access_i,
    input  logic [1:0]        mode_i,
    input  logic              sub_i,
    input  logic [DATA_W-1:0] base_i,
    input  logic [DATA_W-1:0] offset_i,
    output logic [DATA_W-1:0] addr_o,
    output logic              wb_en_o,
    output logic [DATA_W-1:0] wb_data_o
);

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic              wb_en;
        logic [DATA_W-1:0] wb_data;
    } addr_calc_t;

    addr_calc_t        calc_d;
    idx_mode_e         mode;
    logic [DATA_W-1:0] adjusted;

    assign mode     = idx_mode_e'(mode_i);
    assign adjusted = sub_i ? (base_i - offset_i) : (base_i + offset_i);

    always_comb begin
        calc_d.addr    = adjusted;
        calc_d.wb_en   = 1'b0;
        calc_d.wb_data = adjusted;
        case (mode)
            IDX_PRE: begin
                calc_d.addr  = adjusted;
                calc_d.wb_en = access_i;
            end
            IDX_POST: begin
                calc_d.addr  = base_i;
                calc_d.wb_en = access_i;
            end
            default: begin
                calc_d.addr  = adjusted;
                calc_d.wb_en = 1'b0;
            end
        endcase
    end

    assign addr_o    = calc_d.addr;
    assign wb_en_o   = calc_d.wb_en;
    assign wb_data_o = calc_d.wb_data;

endmodule

// File: rtl/lsu_lane_ctrl.sv
module lsu_lane_ctrl
    import lsu_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              access_i,
    input  logic              big_endian_i,
    input  logic [1:0]        size_i,
    input  logic [LANE_W-1:0] addr_lo_i,
    output logic [LANES-1:0]  byte_en_o,
    output logic [LANE_W-1:0] byte_lane_o,
    output logic              half_upper_o
);

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [LANE_W-1:0] lane;
        logic              half_upper;
    } lane_calc_t;

    lane_calc_t        calc_d;
    acc_size_e         size;
    logic [LANES-1:0]  half_mask;

    assign size = acc_size_e'(size_i);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_half_mask
            assign half_mask[k] = ((k / (LANES / 2)) != 0) == calc_d.half_upper;
        end
    endgenerate

    always_comb begin
        calc_d.lane       = big_endian_i ? LANE_W'(LANES - 1) - addr_lo_i : addr_lo_i;
        calc_d.half_upper = big_endian_i ? ~addr_lo_i[LANE_W-1] : addr_lo_i[LANE_W-1];
        calc_d.be         = '0;
        case (size)
            SZ_BYTE: calc_d.be = LANES'(1) << calc_d.lane;
            SZ_HALF: calc_d.be = '0;
            default: calc_d.be = '1;
        endcase
    end

    always_comb begin
        byte_en_o = '0;
        if (access_i) begin
            byte_en_o = (size == SZ_HALF) ? half_mask : calc_d.be;
        end
    end

    assign byte_lane_o  = calc_d.lane;
    assign half_upper_o = calc_d.half_upper;

endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [1:0]        size_i,
    input  logic              signed_i,
    input  logic [LANE_W-1:0] byte_lane_i,
    input  logic              half_upper_i,
    output logic [DATA_W-1:0] load_data_o
);

    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic [DATA_W-1:0] value;
    } ext_calc_t;

    ext_calc_t         calc_d;
    acc_size_e         size;
    logic [7:0]        lane_bytes [LANES];
    logic [7:0]        sel_byte;
    logic [HALF_W-1:0] sel_half;

    assign size = acc_size_e'(size_i);

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lanes
            assign lane_bytes[k] = rdata_i[8*k +: 8];
        end
    endgenerate

    assign sel_byte = lane_bytes[byte_lane_i];
    assign sel_half = half_upper_i ? rdata_i[DATA_W-1:HALF_W] : rdata_i[HALF_W-1:0];

    always_comb begin
        calc_d.value = rdata_i;
        case (size)
            SZ_BYTE: calc_d.value = {{(DATA_W-8){signed_i & sel_byte[7]}}, sel_byte};
            SZ_HALF: calc_d.value = {{(DATA_W-HALF_W){signed_i & sel_half[HALF_W-1]}}, sel_half};
            default: calc_d.value = rdata_i;
        endcase
    end

    assign load_data_o = calc_d.value;

endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
    import lsu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = $clog2(DATA_W),
    parameter int LANES   = DATA_W / 8,
    parameter int LANE_W  = $clog2(LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_big_endian_i,
    input  logic               access_i,
    input  logic [DATA_W-1:0]  base_i,
    input  logic [IMM_W-1:0]   imm_i,
    input  logic [DATA_W-1:0]  index_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    input  logic [1:0]         off_sel_i,
    input  logic               sub_i,
    input  logic [1:0]         mode_i,
    input  logic [1:0]         size_i,
    input  logic               signed_i,
    input  logic [DATA_W-1:0]  rdata_i,
    output logic [DATA_W-1:0]  addr_o,
    output logic [LANES-1:0]   byte_en_o,
    output logic               wb_en_o,
    output logic [DATA_W-1:0]  wb_data_o,
    output logic [DATA_W-1:0]  load_data_o
);

    cfg_state_t        state_d, state_q;
    logic [DATA_W-1:0] offset;
    logic [LANE_W-1:0] byte_lane;
    logic              half_upper;

    // Endianness capture: only follows the pin while reset is held
    always_comb begin
        state_d = state_q;
        if (!rst_n) begin
            state_d.big_endian = cfg_big_endian_i;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    lsu_offset_gen #(
        .DATA_W  (DATA_W),
        .IMM_W   (IMM_W),
        .SHAMT_W (SHAMT_W)
    ) ofs_i (
        .src_i    (off_sel_i),
        .imm_i    (imm_i),
        .index_i  (index_i),
        .shamt_i  (shamt_i),
        .offset_o (offset)
    );

    lsu_addr_gen #(
        .DATA_W (DATA_W)
    ) agen_i (
        .access_i  (access_i),
        .mode_i    (mode_i),
        .sub_i     (sub_i),
        .base_i    (base_i),
        .offset_i  (offset),
        .addr_o    (addr_o),
        .wb_en_o   (wb_en_o),
        .wb_data_o (wb_data_o)
    );

    lsu_lane_ctrl #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) lane_i (
        .access_i     (access_i),
        .big_endian_i (state_q.big_endian),
        .size_i       (size_i),
        .addr_lo_i    (addr_o[LANE_W-1:0]),
        .byte_en_o    (byte_en_o),
        .byte_lane_o  (byte_lane),
        .half_upper_o (half_upper)
    );

    lsu_load_ext #(
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) ext_i (
        .rdata_i      (rdata_i),
        .size_i       (size_i),
        .signed_i     (signed_i),
        .byte_lane_i  (byte_lane),
        .half_upper_i (half_upper),
        .load_data_o  (load_data_o)
    );

    AST_OFFSET_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && (mode_i == 2'd0 || mode_i == 2'd3)) |-> !wb_en_o); // R1

    AST_PRE_WB_IS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && mode_i == 2'd1) |-> (wb_en_o && wb_data_o == addr_o)); // R2

    AST_POST_ADDR_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && mode_i == 2'd2) |-> (wb_en_o && addr_o == base_i)); // R3

    AST_UBYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0 && !signed_i) |-> (load_data_o[DATA_W-1:8] == '0)); // R5

    AST_SBYTE_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0 && signed_i) |->
        (load_data_o[DATA_W-1:8] == {(DATA_W-8){load_data_o[7]}})); // R6

    AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && size_i == 2'd0) |-> ($countones(byte_en_o) == 1)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !access_i |-> (byte_en_o == '0 && !wb_en_o)); // R9

    AST_ENDIAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(state_q.big_endian)); // R10

endmodule

// File: tb/lsu_addr_unit_tb.sv
module lsu_addr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_be;
    logic        access;
    logic [31:0] base, index, rdata;
    logic [11:0] imm;
    logic [4:0]  shamt;
    logic [1:0]  off_sel, mode, size;
    logic        sub, sgn;
    logic [31:0] addr, wb_data, load_data;
    logic [3:0]  be;
    logic        wb_en;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lsu_addr_unit dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_big_endian_i (cfg_be),
        .access_i         (access),
        .base_i           (base),
        .imm_i            (imm),
        .index_i          (index),
        .shamt_i          (shamt),
        .off_sel_i        (off_sel),
        .sub_i            (sub),
        .mode_i           (mode),
        .size_i           (size),
        .signed_i         (sgn),
        .rdata_i          (rdata),
        .addr_o           (addr),
        .byte_en_o        (be),
        .wb_en_o          (wb_en),
        .wb_data_o        (wb_data),
        .load_data_o      (load_data)
    );

    typedef struct packed {
        logic [63:0] tag;
        logic [1:0]  mode;
        logic [1:0]  osel;
        logic        sub;
        logic [31:0] base;
        logic [11:0] imm;
        logic [31:0] idx;
        logic [4:0]  sh;
        logic [1:0]  size;
        logic        sgn;
        logic [31:0] rdata;
        logic [31:0] e_addr;
        logic [3:0]  e_be;
        logic        e_wben;
        logic [31:0] e_wb;
        logic [31:0] e_load;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{"R1 R4",  2'd0, 2'd0, 1'b0, 32'h1000, 12'h008, 32'h0, 5'd0, 2'd2, 1'b0,
          32'hDEADBEEF, 32'h1008, 4'b1111, 1'b0, 32'h0, 32'hDEADBEEF},
        '{"R2 R5",  2'd1, 2'd1, 1'b0, 32'h2000, 12'h000, 32'h10, 5'd0, 2'd0, 1'b0,
          32'h44332211, 32'h2010, 4'b0001, 1'b1, 32'h2010, 32'h00000011},
        '{"R3 R7",  2'd2, 2'd2, 1'b1, 32'h3000, 12'h000, 32'h3, 5'd2, 2'd1, 1'b1,
          32'h12348001, 32'h3000, 4'b0011, 1'b1, 32'h2FF4, 32'hFFFF8001},
        '{"R6 R8",  2'd0, 2'd0, 1'b1, 32'h103, 12'h002, 32'h0, 5'd0, 2'd0, 1'b1,
          32'h00008A00, 32'h101, 4'b0010, 1'b0, 32'h0, 32'hFFFFFF8A},
        '{"R5 R9",  2'd0, 2'd0, 1'b0, 32'h100, 12'h003, 32'h0, 5'd0, 2'd0, 1'b0,
          32'hF0000000, 32'h103, 4'b1000, 1'b0, 32'h0, 32'h000000F0},
        '{"R7 R2",  2'd1, 2'd1, 1'b0, 32'h200, 12'h000, 32'h2, 5'd0, 2'd1, 1'b0,
          32'hABCD0000, 32'h202, 4'b1100, 1'b1, 32'h202, 32'h0000ABCD},
        '{"R4 rsv", 2'd0, 2'd3, 1'b0, 32'h400, 12'h004, 32'h99, 5'd0, 2'd2, 1'b0,
          32'h01020304, 32'h404, 4'b1111, 1'b0, 32'h0, 32'h01020304},
        '{"R4 shl", 2'd0, 2'd2, 1'b1, 32'h10000, 12'h000, 32'h1, 5'd8, 2'd3, 1'b0,
          32'h55AA55AA, 32'hFF00, 4'b1111, 1'b0, 32'h0, 32'h55AA55AA},
        '{"R1 rsv", 2'd3, 2'd0, 1'b0, 32'h50, 12'h010, 32'h0, 5'd0, 2'd2, 1'b1,
          32'h80000000, 32'h60, 4'b1111, 1'b0, 32'h0, 32'h80000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [1:0] os, input logic s,
                         input logic [31:0] b, input logic [11:0] im,
                         input logic [31:0] ix, input logic [4:0] sh,
                         input logic [1:0] sz, input logic sg, input logic [31:0] rd);
        @(negedge clk);
        access = 1'b1; mode = m; off_sel = os; sub = s; base = b; imm = im;
        index = ix; shamt = sh; size = sz; sgn = sg; rdata = rd;
        #1;
    endtask

    task automatic do_reset(input logic cfg);
        @(negedge clk);
        rst_n = 1'b0; cfg_be = cfg; access = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_be = 1'b0; access = 1'b0;
        base = '0; index = '0; rdata = '0; imm = '0; shamt = '0;
        off_sel = '0; mode = 2'd1; size = '0; sub = 1'b0; sgn = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // Reset state, idle: no enables, no writeback
        chk("R9 reset be", {28'd0, be}, 32'd0);
        chk("R9 reset wb_en", {31'd0, wb_en}, 32'd0);
        rst_n = 1'b1;

        // Little-endian vector table; outputs due same cycle (R11)
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].mode, VECS[i].osel, VECS[i].sub, VECS[i].base, VECS[i].imm,
                  VECS[i].idx, VECS[i].sh, VECS[i].size, VECS[i].sgn, VECS[i].rdata);
            chk({string'(VECS[i].tag), " R11 addr"}, addr, VECS[i].e_addr);
            chk({string'(VECS[i].tag), " be"}, {28'd0, be}, {28'd0, VECS[i].e_be});
            chk({string'(VECS[i].tag), " wb_en"}, {31'd0, wb_en}, {31'd0, VECS[i].e_wben});
            if (VECS[i].e_wben) chk({string'(VECS[i].tag), " wb"}, wb_data, VECS[i].e_wb);
            chk({string'(VECS[i].tag), " load"}, load_data, VECS[i].e_load);
        end

        // R9: idle access with pre-indexed mode selected
        drive(2'd1, 2'd0, 1'b0, 32'h700, 12'h4, 32'h0, 5'd0, 2'd0, 1'b0, 32'h0);
        @(negedge clk); access = 1'b0; #1;
        chk("R9 idle be", {28'd0, be}, 32'd0);
        chk("R9 idle wb_en", {31'd0, wb_en}, 32'd0);

        // R8/R10: big-endian captured during reset
        do_reset(1'b1);
        drive(2'd0, 2'd0, 1'b0, 32'h100, 12'h0, 32'h0, 5'd0, 2'd0, 1'b0, 32'h11223344);
        chk("R8 BE byte0 load", load_data, 32'h11);
        chk("R8 BE byte0 be", {28'd0, be}, 32'h8);
        drive(2'd0, 2'd0, 1'b0, 32'h100, 12'h1, 32'h0, 5'd0, 2'd0, 1'b0, 32'h11223344);
        chk("R8 BE byte1 load", load_data, 32'h22);
        chk("R8 BE byte1 be", {28'd0, be}, 32'h4);
        drive(2'd0, 2'd0, 1'b0, 32'h100, 12'h0, 32'h0, 5'd0, 2'd1, 1'b0, 32'h11223344);
        chk("R8 BE half0 load", load_data, 32'h1122);
        chk("R8 BE half0 be", {28'd0, be}, 32'hC);
        drive(2'd0, 2'd0, 1'b0, 32'h100, 12'h3, 32'h0, 5'd0, 2'd1, 1'b1, 32'h11228899);
        chk("R7 R8 BE half1 signed", load_data, 32'hFFFF8899);
        chk("R8 BE half1 be", {28'd0, be}, 32'h3);
        drive(2'd0, 2'd0, 1'b0, 32'h100, 12'h0, 32'h0, 5'd0, 2'd2, 1'b0, 32'h11223344);
        chk("R8 BE word", load_data, 32'h11223344);

        // R10: changing the pin out of reset has no effect
        @(negedge clk); cfg_be = 1'b0;
        repeat (4) @(posedge clk);
        drive(2'd0, 2'd0, 1'b0, 32'h100, 12'h0, 32'h0, 5'd0, 2'd0, 1'b0, 32'h11223344);
        chk("R10 pin ignored load", load_data, 32'h11);
        chk("R10 pin ignored be", {28'd0, be}, 32'h8);

        // R10: a fresh reset with little-endian restores default order
        do_reset(1'b0);
        drive(2'd0, 2'd0, 1'b0, 32'h100, 12'h0, 32'h0, 5'd0, 2'd0, 1'b0, 32'h11223344);
        chk("R10 R8 LE restored", load_data, 32'h44);
        chk("R10 R8 LE be", {28'd0, be}, 32'h1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule